// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects an on-chip bus master to an external 32K-word by 16-bit asynchronous static RAM. The master presents a one-cycle request with a read/write flag, a word address, write data and one enable bit per byte lane. The controller runs the access on the memory pins and then returns a single-cycle completion strobe. For reads, the returned word appears on the read data output in the same cycle as that strobe.

Each access passes through a fixed sequence of phases: a setup cycle, then a wait phase of configurable length, then a hold cycle. The wait phase is a read wait with chip enable and output enable low, or a write pulse with write enable low. The phase lengths are parameters counted in system clocks. Choose them by rounding the memory's nanosecond limits up to whole clock periods. When a write follows a read, the controller inserts dead cycles so that the memory has released the shared data bus before the controller drives it. All memory strobes come straight from flops, so none of them can glitch.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all memory strobes (chip, write, output and both lane controls) are high, the data driver enable is 0, the completion strobe is 0 and the read data is 0.
- R2: A request is taken only when the controller is idle. A request raised during an access is ignored and does not change the memory contents.
- R3: An accepted read drives chip enable and output enable low for 1 + RD_CYC cycles, with write enable high throughout. The data bus is sampled at the end of the last of those cycles.
- R4: An accepted write holds write enable low for exactly WR_PULSE cycles. Output enable stays high and chip enable stays low throughout. The address stays stable from the setup cycle through the hold cycle.
- R5: The controller enables its data driver only in the setup, pulse and hold cycles of a write. It presents the latched write data for that whole span.
- R6: Lane control bit 0 gates data bits 7..0 and bit 1 gates bits 15..8. During an access each lane control is the inverse of the accepted byte enable (enable 1 gives control 0). Outside an access both are high.
- R7: In a read, a lane whose byte enable is 0 returns 0 in the read data.
- R8: After a read, the data driver is not enabled until output enable has been high for at least TURN consecutive cycles.
- R9: The completion strobe is high for exactly one cycle: the hold cycle, which is 2 + RD_CYC cycles after a read is accepted and 2 + WR_PULSE cycles after a write is accepted (with no turnaround wait). Read data then holds until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | Access request, sampled only when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | LANES | Byte enables, bit 0 = bits 7..0 |
| rdata_o | output | DATA_W | Read data, valid with done_o after a read |
| done_o | output | 1 | One-cycle completion strobe |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_dq_o | output | DATA_W | Data towards the memory |
| sram_dq_oe | output | 1 | Enable for the external data bus driver |
| sram_dq_i | input | DATA_W | Data from the memory |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_bl_n | output | LANES | Byte lane controls, active low, bit 0 = low byte |

## Verification
The assertions assume that the TURN value given to the checker is the one the controller runs with. They also assume that a request arriving during an access may carry any data. They rely only on the pin strobes and the completion strobe, never on the memory's returned data. The stimulus keeps within these assumptions. Requests last one cycle except in a deliberate case, where a request is held high with unrelated fields through a whole access to show it is ignored. A behavioural memory in the bench answers only when chip enable and output enable are low with write enable high. It returns a filler byte on disabled lanes, so a lane that is wrongly captured shows up as a wrong value.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_RDWAIT,
    ST_WRPULSE,
    ST_HOLD
  } sc_state_e;
endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 3,
  parameter int WR_PULSE = 2,
  parameter int TURN     = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_i,
  input  logic      we_i,
  input  logic      op_we,
  output logic      accept_o,
  output logic      capture_o,
  output sc_state_e st_nxt_o
);
  localparam int WMAX = (RD_CYC > WR_PULSE) ? RD_CYC : WR_PULSE;
  localparam int CW   = $clog2(WMAX + 1);
  localparam int TW   = $clog2(TURN + 2);

  sc_state_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [TW-1:0]   tc_q, tc_d;
  logic            wait_end;

  assign accept_o  = (st_q == ST_IDLE) && req_i;
  assign wait_end  = (cnt_q == '0);
  assign capture_o = (st_q == ST_RDWAIT) && wait_end;
  assign st_nxt_o  = st_d;

  // next-state and counters
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:
        if (req_i) st_d = (we_i && (tc_q > TW'(1))) ? ST_TURN : ST_SETUP;
      ST_TURN:
        if (tc_q <= TW'(1)) st_d = ST_SETUP;
      ST_SETUP: begin
        st_d  = op_we ? ST_WRPULSE : ST_RDWAIT;
        cnt_d = op_we ? CW'(WR_PULSE - 1) : CW'(RD_CYC - 1);
      end
      ST_RDWAIT, ST_WRPULSE:
        if (wait_end) st_d = ST_HOLD;
        else          cnt_d = cnt_q - CW'(1);
      ST_HOLD:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    // turnaround: loaded when output enable is about to be released
    if (capture_o)          tc_d = TW'(TURN);
    else if (tc_q != '0)    tc_d = tc_q - TW'(1);
    else                    tc_d = tc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      tc_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
    end
  end
endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              we_q,
  output logic              we_nxt,
  output logic [LANES-1:0]  be_nxt,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int LW = DATA_W / LANES;

  logic [LANES-1:0] be_q;

  assign we_nxt = accept ? we_i : we_q;
  assign be_nxt = accept ? be_i : be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      we_q    <= we_i;
      be_q    <= be_i;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q[l*LW +: LW] <= '0;
      else if (capture) rdata_q[l*LW +: LW] <= be_q[l] ? dq_i[l*LW +: LW] : '0;
    end
  end
endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sc_state_e        st_nxt,
  input  logic             we_nxt,
  input  logic [LANES-1:0] be_nxt,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [LANES-1:0] bl_n,
  output logic             dq_oe,
  output logic             done
);
  logic             act, ce_d, we_d, oe_d, dq_oe_d, done_d;
  logic [LANES-1:0] bl_d;

  always_comb begin
    act     = (st_nxt == ST_SETUP) || (st_nxt == ST_RDWAIT) ||
              (st_nxt == ST_WRPULSE) || (st_nxt == ST_HOLD);
    ce_d    = ~act;
    we_d    = ~(st_nxt == ST_WRPULSE);
    oe_d    = ~(!we_nxt && ((st_nxt == ST_SETUP) || (st_nxt == ST_RDWAIT)));
    dq_oe_d = we_nxt && ((st_nxt == ST_SETUP) || (st_nxt == ST_WRPULSE) ||
                         (st_nxt == ST_HOLD));
    done_d  = (st_nxt == ST_HOLD);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_bl
    assign bl_d[l] = ~(act && be_nxt[l]);
  end

  // every pin strobe leaves a flop: no decode glitches reach the memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      bl_n  <= '1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      ce_n  <= ce_d;
      we_n  <= we_d;
      oe_n  <= oe_d;
      bl_n  <= bl_d;
      dq_oe <= dq_oe_d;
      done  <= done_d;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter  int ADDR_W   = 15,
  parameter  int DATA_W   = 16,
  parameter  int RD_CYC   = 3,
  parameter  int WR_PULSE = 2,
  parameter  int TURN     = 2,
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [LANES-1:0]  sram_bl_n
);
  sc_state_e        st_nxt;
  logic             accept, capture, op_we, we_nxt;
  logic [LANES-1:0] be_nxt;

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WR_PULSE(WR_PULSE), .TURN(TURN)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .op_we(op_we),
    .accept_o(accept), .capture_o(capture), .st_nxt_o(st_nxt)
  );

  sram_ctrl_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i),
    .dq_i(sram_dq_i), .addr_q(sram_addr), .wdata_q(sram_dq_o),
    .we_q(op_we), .we_nxt(we_nxt), .be_nxt(be_nxt), .rdata_q(rdata_o)
  );

  sram_ctrl_pins #(.LANES(LANES)) u_pins (
    .clk(clk), .rst_n(rst_n), .st_nxt(st_nxt), .we_nxt(we_nxt),
    .be_nxt(be_nxt), .ce_n(sram_ce_n), .we_n(sram_we_n), .oe_n(sram_oe_n),
    .bl_n(sram_bl_n), .dq_oe(sram_dq_oe), .done(done_o)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int LANES  = 2,
  parameter int TURN   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [LANES-1:0]  sram_bl_n,
  input logic              sram_dq_oe,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              done_o
);
  localparam int GW = $clog2(TURN + 2);

  // consecutive cycles with output enable released, saturating at TURN
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap_q <= GW'(TURN);
    else if (!sram_oe_n)         gap_q <= '0;
    else if (gap_q < GW'(TURN))  gap_q <= gap_q + GW'(1);
  end

  assert_we_blocks_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  assert_we_inside_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

  assert_addr_stable_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr));

  assert_no_bus_fight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  assert_idle_lanes_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n |-> (sram_bl_n == '1) && sram_we_n && sram_oe_n && !sram_dq_oe);

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (gap_q >= GW'(TURN)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_in_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !sram_ce_n && sram_we_n && sram_oe_n);
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .TURN(TURN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .sram_bl_n(sram_bl_n), .sram_dq_oe(sram_dq_oe),
  .sram_addr(sram_addr), .done_o(done_o)
);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RDC = 3;
  localparam int WRP = 2;
  localparam int TRN = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, we_i;
  logic [14:0] addr_i;
  logic [15:0] wdata_i;
  logic [1:0]  be_i;
  logic [15:0] rdata_o, sram_dq_o, sram_dq_i;
  logic        done_o, sram_dq_oe, sram_ce_n, sram_we_n, sram_oe_n;
  logic [14:0] sram_addr;
  logic [1:0]  sram_bl_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl #(.RD_CYC(RDC), .WR_PULSE(WRP), .TURN(TRN)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .be_i(be_i), .rdata_o(rdata_o), .done_o(done_o),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(sram_dq_i), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_bl_n(sram_bl_n)
  );

  // ---------------- behavioural memory on the pins ----------------
  logic [15:0] sram_mem [int];
  always @(posedge sram_we_n) begin
    if (!sram_ce_n) begin
      logic [15:0] w;
      w = sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : 16'h0;
      if (!sram_bl_n[0] && sram_dq_oe) w[7:0]  = sram_dq_o[7:0];
      if (!sram_bl_n[1] && sram_dq_oe) w[15:8] = sram_dq_o[15:8];
      sram_mem[int'(sram_addr)] = w;
    end
  end
  always @(negedge clk) begin
    logic [15:0] v;
    v = sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : 16'h0;
    if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
      sram_dq_i[7:0]  <= sram_bl_n[0] ? 8'hA5 : v[7:0];
      sram_dq_i[15:8] <= sram_bl_n[1] ? 8'hA5 : v[15:8];
    end else begin
      sram_dq_i <= 16'hA5A5;
    end
  end

  // ---------------- reference model ----------------
  // phases: 0 idle, 1 turnaround, 2 setup, 3 read wait, 4 write pulse, 5 hold
  int          m_ph, m_cnt, m_t;
  bit          m_we;
  logic [14:0] m_addr;
  logic [15:0] m_wd, m_rd, last_done_rd;
  logic [1:0]  m_be;
  logic [15:0] shadow [int];
  int          b_gap;
  bit          prev_oe;

  function automatic logic [15:0] sh_rd(logic [14:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    bit act;
    logic [1:0] ebl;
    act = (m_ph >= 2);
    ebl = act ? ~m_be : 2'b11;
    chk(sram_ce_n == !act, "R3", "ce_n", 32'(sram_ce_n), 32'(!act));
    chk(sram_oe_n == !(!m_we && (m_ph == 2 || m_ph == 3)), "R3", "oe_n",
        32'(sram_oe_n), 32'(!(!m_we && (m_ph == 2 || m_ph == 3))));
    chk(sram_we_n == !(m_ph == 4), "R4", "we_n", 32'(sram_we_n), 32'(!(m_ph == 4)));
    chk(sram_bl_n == ebl, "R6", "lane controls", 32'(sram_bl_n), 32'(ebl));
    chk(sram_dq_oe == (m_we && (m_ph == 2 || m_ph == 4 || m_ph == 5)), "R5", "dq_oe",
        32'(sram_dq_oe), 32'(m_we && (m_ph == 2 || m_ph == 4 || m_ph == 5)));
    chk(done_o == (m_ph == 5), "R9", "done", 32'(done_o), 32'(m_ph == 5));
    chk(rdata_o == m_rd, "R7", "rdata", 32'(rdata_o), 32'(m_rd));
    if (act) chk(sram_addr == m_addr, "R4", "address", 32'(sram_addr), 32'(m_addr));
    if (sram_dq_oe) chk(sram_dq_o == m_wd, "R5", "write data", 32'(sram_dq_o), 32'(m_wd));
    if (sram_dq_oe && !prev_oe)
      chk(b_gap >= TRN, "R8", "oe high cycles before drive", 32'(b_gap), 32'(TRN));
    if (done_o) last_done_rd = rdata_o;
    prev_oe = sram_dq_oe;
    b_gap = sram_oe_n ? b_gap + 1 : 0;
  endtask

  task automatic advance();
    int nt;
    logic [15:0] s;
    nt = (m_ph == 3 && m_cnt == 0) ? TRN : ((m_t > 0) ? m_t - 1 : 0);
    case (m_ph)
      0: if (req_i) begin
           m_we = we_i; m_addr = addr_i; m_wd = wdata_i; m_be = be_i;
           m_ph = (we_i && m_t > 1) ? 1 : 2;
         end
      1: if (m_t <= 1) m_ph = 2;
      2: begin m_ph = m_we ? 4 : 3; m_cnt = (m_we ? WRP : RDC) - 1; end
      3: if (m_cnt == 0) begin
           s = sh_rd(m_addr);
           m_rd = {m_be[1] ? s[15:8] : 8'h00, m_be[0] ? s[7:0] : 8'h00};
           m_ph = 5;
         end else m_cnt--;
      4: if (m_cnt == 0) begin
           s = sh_rd(m_addr);
           if (m_be[0]) s[7:0]  = m_wd[7:0];
           if (m_be[1]) s[15:8] = m_wd[15:8];
           shadow[int'(m_addr)] = s;
           m_ph = 5;
         end else m_cnt--;
      default: m_ph = 0;
    endcase
    m_t = nt;
  endtask

  task automatic step(bit r, bit w, logic [14:0] a, logic [15:0] d, logic [1:0] b);
    @(negedge clk);
    compare();
    req_i = r; we_i = w; addr_i = a; wdata_i = d; be_i = b;
    advance();
  endtask

  // one access; junk = keep a foreign write request raised while busy
  task automatic op(bit w, logic [14:0] a, logic [15:0] d, logic [1:0] b, bit junk,
                    output logic [15:0] rd);
    int n = 0;
    int lat = 0;
    step(1'b1, w, a, d, b);
    while (m_ph != 0 && n < 100) begin
      if (m_ph == 5) lat = n + 2;
      if (junk) step(1'b1, 1'b1, 15'h0100, 16'hFFFF, 2'b11);
      else      step(1'b0, 1'b0, 15'h0, 16'h0, 2'b00);
      n++;
    end
    chk(n < 100, "R9", "access completes", 32'(n), 32'(100));
    rd = last_done_rd;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    m_ph = 0; m_cnt = 0; m_t = 0; m_we = 0; m_addr = '0; m_wd = '0;
    m_rd = '0; m_be = '0; last_done_rd = '0; b_gap = 1000; prev_oe = 0;
    rst_n = 1'b0; req_i = 0; we_i = 0; addr_i = '0; wdata_i = '0; be_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state, then the first cycle after release
    chk({sram_ce_n, sram_we_n, sram_oe_n, sram_bl_n, sram_dq_oe, done_o} == 7'b1111100,
        "R1", "pins in reset",
        32'({sram_ce_n, sram_we_n, sram_oe_n, sram_bl_n, sram_dq_oe, done_o}), 32'h7C);
    chk(rdata_o == 16'h0, "R1", "rdata in reset", 32'(rdata_o), 32'h0);
    rst_n = 1'b1;
    step(0, 0, '0, '0, '0);
    step(0, 0, '0, '0, '0);

    // writes at both ends of the address range (R4, R5, R6)
    op(1, 15'h0000, 16'h1234, 2'b11, 0, rd);
    op(1, 15'h7FFF, 16'hABCD, 2'b11, 0, rd);
    // read followed at once by a write: turnaround path (R3, R8)
    op(0, 15'h0000, 16'h0, 2'b11, 0, rd);
    chk(rd == 16'h1234, "R3", "read back addr 0", 32'(rd), 32'h1234);
    op(1, 15'h0005, 16'h5566, 2'b01, 0, rd);
    // upper lane only read (R7)
    op(0, 15'h7FFF, 16'h0, 2'b10, 0, rd);
    chk(rd == 16'hAB00, "R7", "upper-lane read", 32'(rd), 32'hAB00);
    op(0, 15'h7FFF, 16'h0, 2'b01, 0, rd);
    chk(rd == 16'h00CD, "R7", "lower-lane read", 32'(rd), 32'h00CD);
    // upper lane only write merges (R6)
    op(1, 15'h0000, 16'h9900, 2'b10, 0, rd);
    op(0, 15'h0000, 16'h0, 2'b11, 0, rd);
    chk(rd == 16'h9934, "R6", "merged lanes", 32'(rd), 32'h9934);
    // request held during a busy access is ignored (R2)
    op(1, 15'h0100, 16'h4242, 2'b11, 0, rd);
    op(0, 15'h0005, 16'h0, 2'b11, 1, rd);
    chk(rd == 16'h0066, "R2", "read during foreign request", 32'(rd), 32'h0066);
    op(0, 15'h0100, 16'h0, 2'b11, 0, rd);
    chk(rd == 16'h4242, "R2", "ignored write left memory", 32'(rd), 32'h4242);
    // write with no lanes enabled changes nothing (R6)
    op(1, 15'h0005, 16'hFFFF, 2'b00, 0, rd);
    op(0, 15'h0005, 16'h0, 2'b11, 0, rd);
    chk(rd == 16'h0066, "R6", "no-lane write", 32'(rd), 32'h0066);
    // back-to-back sweep
    for (int i = 0; i < 8; i++)
      op(1, 15'(i * 517), 16'(i * 16'h1357 + 3), 2'b11, 0, rd);
    for (int i = 0; i < 8; i++) begin
      op(0, 15'(i * 517), 16'h0, 2'b11, 0, rd);
      chk(rd == 16'(i * 16'h1357 + 3), "R3", "sweep read", 32'(rd),
          32'(16'(i * 16'h1357 + 3)));
    end
    // reads alternating with writes, plus idle gaps (R8, R9)
    for (int i = 0; i < 4; i++) begin
      op(0, 15'h7FFF, 16'h0, 2'b11, 0, rd);
      op(1, 15'(16 + i), 16'(16'hC000 + i), 2'b11, 0, rd);
      step(0, 0, '0, '0, '0);
    end
    repeat (3) step(0, 0, '0, '0, '0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule